// File: doc/BRIEF.md
# Escape-Coded Extraction Word Decoder

This block turns a stream of 32-bit words, read one at a time from a CPU extraction queue, back into a frame. A fixed number of header words starts every frame. The block stores them and takes a source port number from a forwarding field inside them. Every word after the header is either frame data or one of eight reserved status words, 0x80000000 to 0x80000007. These status words mark the end of the frame (0x80000000 to 0x80000003), a pruned frame (…004), an aborted frame (…005), an escape (…006) or an idle slot (…007).

The status word for end of frame arrives only after the last data word. For this reason the block holds each data word back by one word before it sends it out. On the output side it gives one 32-bit beat per data word, with start and end markers, the count of valid bytes in the last beat, a discard verdict and the frame length with the 4-byte FCS removed. An optional byte swap makes the code comparison run on the reversed word, while data words always pass through unchanged. If the source port is out of range, the block raises a flush request and the whole frame is suppressed at the output.

Top module: `extr_decoder`

## Requirements
- R1: The first HDR_WORDS words accepted after reset or after a frame end are stored in `hdr_bits` (word k at bits 32k+31:32k) and are never decoded as codes. No output beat is produced for them.
- R2: `src_port` is bits 7:1 of the value built from header bytes 27, 28, 29 and 30, taken most significant first and shifted right by 5. Header byte b is bits 8*(b%4)+7 : 8*(b%4) of header word b/4. The value is updated on the edge that accepts the last header word.
- R3: Each data word appears unchanged on `out_data` with `out_bytes` = 4, in arrival order. Only the first beat of a frame has `out_sof` = 1.
- R4: A code 0x80000000+n with n in 0..3 puts `out_eof` on the beat of the last data word, with `out_bytes` = 4 − n and `out_drop` = 0.
- R5: On a kept end-of-frame beat, `frame_len` = 4 × (data words) − n − 4, or 0 if that would be negative. On a dropped end-of-frame beat, `frame_len` = 0.
- R6: After the escape code 0x80000006, the next word is frame data even if it equals a code value.
- R7: The idle code 0x80000007 is skipped. It produces no beat and adds no bytes.
- R8: After the pruned code 0x80000004, the next word is taken as the last data word. `in_ready` is low for exactly one cycle, and the frame then ends with `out_eof` = 1, `out_drop` = 1 and `out_bytes` = 4.
- R9: The abort code 0x80000005 ends the frame at once with `out_drop` = 1. The last beat carries any held data word with `out_bytes` = 4. If no data word is held, the last beat has `out_data` = 0 and `out_bytes` = 0.
- R10: With `swap_en` = 1, codes are recognised on the byte-reversed input word. A raw word that is a code only before reversal is treated as data. Data leaves unreversed.
- R11: If the source port is PORT_CNT or higher, `flush_req` pulses for one cycle and no beat of that frame is produced.
- R12: During and after reset, `out_valid` = 0, `flush_req` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_en | input | 1 | Compare codes on the byte-reversed word |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_word | input | 32 | Word read from the queue |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 32 | Frame data word |
| out_sof | output | 1 | First beat of frame |
| out_eof | output | 1 | Last beat of frame |
| out_bytes | output | 3 | Valid bytes in this beat |
| out_drop | output | 1 | Frame must be discarded (end beat) |
| frame_len | output | LEN_W | Frame length without FCS (end beat) |
| src_port | output | PORT_W | Source port from the header |
| flush_req | output | 1 | Pulse: header named an unknown port |
| hdr_bits | output | 32*HDR_WORDS | Stored header words |

## Verification
The assertions check properties that must hold on every cycle:
- Every beat that is not the last is a full word.
- End and start markers never appear without a valid beat.
- A dropped frame reports zero length.
- A stall lasts only one cycle.
- A flush request never lasts longer than one cycle.

Other behaviour can only be shown by the bench's word sequences:
- Which words become data and which become codes, and in what order.
- The exact byte counts and lengths.
- The escape and idle handling.
- How the swap setting affects code recognition.
- The bit positions that form the source port.

// File: rtl/extr_pkg.sv
package extr_pkg;
  localparam int WORD_W = 32;
  localparam logic [28:0] CODE_TAG = 29'h1000_0000;
  localparam logic [2:0] K_PRUNE = 3'd4;
  localparam logic [2:0] K_ABORT = 3'd5;
  localparam logic [2:0] K_ESC   = 3'd6;
  localparam logic [2:0] K_IDLE  = 3'd7;

  typedef enum logic [2:0] {
    S_HDR, S_BODY, S_ESC, S_PRUNE, S_LAST
  } dec_st_e;

  function automatic logic [WORD_W-1:0] rev_bytes(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/extr_code_classify.sv
module extr_code_classify
  import extr_pkg::*;
(
  input  logic              swap_en,
  input  logic [WORD_W-1:0] word,
  output logic              is_code,
  output logic [2:0]        kind
);
  logic [WORD_W-1:0] cmp_w;

  always_comb begin
    cmp_w   = swap_en ? rev_bytes(word) : word;
    is_code = (cmp_w[WORD_W-1:3] == CODE_TAG);
    kind    = cmp_w[2:0];
  end
endmodule

// File: rtl/extr_hdr_capture.sv
module extr_hdr_capture
  import extr_pkg::*;
#(
  parameter int HDR_WORDS = 9,
  parameter int PORT_W    = 7,
  parameter int PORT_CNT  = 65,
  parameter int FWD_BYTE  = 27
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr,
  input  logic [WORD_W-1:0]           word,
  output logic                        done,
  output logic                        bad_nx,
  output logic                        port_bad,
  output logic [PORT_W-1:0]           src_port,
  output logic [HDR_WORDS*WORD_W-1:0] hdr_bits
);
  localparam int CNT_W = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(HDR_WORDS - 1);
  localparam logic [PORT_W:0] PORT_LIM = (PORT_W + 1)'(PORT_CNT);
  localparam int B0 = FWD_BYTE;
  localparam int B1 = FWD_BYTE + 1;
  localparam int B2 = FWD_BYTE + 2;
  localparam int B3 = FWD_BYTE + 3;

  logic [CNT_W-1:0]            cnt_q;
  logic [HDR_WORDS*WORD_W-1:0] hdr_q;
  logic [HDR_WORDS*WORD_W-1:0] hdr_nx;
  logic [WORD_W-1:0]           fwd_raw;
  logic [PORT_W-1:0]           src_nx;

  for (genvar g = 0; g < HDR_WORDS; g++) begin : g_slot
    assign hdr_nx[g*WORD_W +: WORD_W] =
      (wr && cnt_q == CNT_W'(g)) ? word : hdr_q[g*WORD_W +: WORD_W];
  end

  assign done = wr && (cnt_q == LAST_IDX);

  always_comb begin
    fwd_raw = {hdr_nx[(B0/4)*WORD_W + 8*(B0%4) +: 8],
               hdr_nx[(B1/4)*WORD_W + 8*(B1%4) +: 8],
               hdr_nx[(B2/4)*WORD_W + 8*(B2%4) +: 8],
               hdr_nx[(B3/4)*WORD_W + 8*(B3%4) +: 8]};
    src_nx  = PORT_W'(fwd_raw >> 6);
    bad_nx  = ({1'b0, src_nx} >= PORT_LIM);
  end

  always_ff @(posedge clk) begin
    if (wr) hdr_q <= hdr_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      src_port <= '0;
      port_bad <= 1'b0;
    end else if (wr) begin
      cnt_q <= done ? '0 : cnt_q + 1'b1;
      if (done) begin
        src_port <= src_nx;
        port_bad <= bad_nx;
      end
    end
  end

  assign hdr_bits = hdr_q;
endmodule

// File: rtl/extr_len_acc.sv
module extr_len_acc #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add4,
  output logic [LEN_W-1:0] len_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) len_q <= '0;
    else if (add4)  len_q <= len_q + LEN_W'(4);
  end
endmodule

// File: rtl/extr_decoder.sv
module extr_decoder
  import extr_pkg::*;
#(
  parameter int HDR_WORDS = 9,
  parameter int PORT_W    = 7,
  parameter int PORT_CNT  = 65,
  parameter int LEN_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        swap_en,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [WORD_W-1:0]           in_word,
  output logic                        out_valid,
  output logic [WORD_W-1:0]           out_data,
  output logic                        out_sof,
  output logic                        out_eof,
  output logic [2:0]                  out_bytes,
  output logic                        out_drop,
  output logic [LEN_W-1:0]            frame_len,
  output logic [PORT_W-1:0]           src_port,
  output logic                        flush_req,
  output logic [HDR_WORDS*WORD_W-1:0] hdr_bits
);
  dec_st_e           st_q, st_d;
  logic              acc, is_code, hdr_wr, hdr_done, bad_nx, port_bad;
  logic [2:0]        kind;
  logic [LEN_W-1:0]  len_q, trim, fin_len;
  logic [WORD_W-1:0] pend_d;
  logic              pend_v, sof_due;
  logic              do_push, do_fin, fin_drop;
  logic [2:0]        fin_bytes;

  assign in_ready = (st_q != S_LAST);
  assign acc      = in_valid && in_ready;
  assign hdr_wr   = acc && (st_q == S_HDR);

  extr_code_classify u_cls (
    .swap_en (swap_en),
    .word    (in_word),
    .is_code (is_code),
    .kind    (kind)
  );

  extr_hdr_capture #(
    .HDR_WORDS (HDR_WORDS),
    .PORT_W    (PORT_W),
    .PORT_CNT  (PORT_CNT)
  ) u_hdr (
    .clk      (clk),
    .rst      (rst),
    .wr       (hdr_wr),
    .word     (in_word),
    .done     (hdr_done),
    .bad_nx   (bad_nx),
    .port_bad (port_bad),
    .src_port (src_port),
    .hdr_bits (hdr_bits)
  );

  extr_len_acc #(.LEN_W(LEN_W)) u_len (
    .clk   (clk),
    .rst   (rst),
    .clr   (hdr_done),
    .add4  (do_push),
    .len_q (len_q)
  );

  // next-state and beat decisions
  always_comb begin
    st_d      = st_q;
    do_push   = 1'b0;
    do_fin    = 1'b0;
    fin_drop  = 1'b0;
    fin_bytes = 3'd0;
    unique case (st_q)
      S_HDR: if (hdr_done) st_d = S_BODY;
      S_BODY: begin
        if (acc) begin
          if (!is_code) begin
            do_push = 1'b1;
          end else begin
            unique case (kind)
              K_IDLE:  ;
              K_ESC:   st_d = S_ESC;
              K_PRUNE: st_d = S_PRUNE;
              K_ABORT: begin
                do_fin    = 1'b1;
                fin_drop  = 1'b1;
                fin_bytes = pend_v ? 3'd4 : 3'd0;
              end
              default: begin
                do_fin    = 1'b1;
                fin_drop  = !pend_v;
                fin_bytes = pend_v ? (3'd4 - {1'b0, kind[1:0]}) : 3'd0;
              end
            endcase
          end
        end
      end
      S_ESC: if (acc) begin
        do_push = 1'b1;
        st_d    = S_BODY;
      end
      S_PRUNE: if (acc) begin
        do_push = 1'b1;
        st_d    = S_LAST;
      end
      S_LAST: begin
        do_fin    = 1'b1;
        fin_drop  = 1'b1;
        fin_bytes = 3'd4;
      end
      default: st_d = S_HDR;
    endcase
    if (do_fin) st_d = S_HDR;
    trim    = LEN_W'(kind[1:0]) + LEN_W'(4);
    fin_len = (!fin_drop && len_q > trim) ? (len_q - trim) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_HDR;
      pend_v    <= 1'b0;
      pend_d    <= '0;
      sof_due   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_bytes <= 3'd0;
      out_drop  <= 1'b0;
      frame_len <= '0;
      flush_req <= 1'b0;
    end else begin
      st_q      <= st_d;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_drop  <= 1'b0;
      out_bytes <= 3'd0;
      frame_len <= '0;
      flush_req <= hdr_done && bad_nx;
      if (hdr_done) begin
        sof_due <= 1'b1;
        pend_v  <= 1'b0;
      end
      if (do_push) begin
        pend_d <= in_word;
        pend_v <= 1'b1;
        if (pend_v) begin
          out_valid <= !port_bad;
          out_data  <= pend_d;
          out_sof   <= sof_due && !port_bad;
          out_bytes <= 3'd4;
          sof_due   <= 1'b0;
        end
      end
      if (do_fin) begin
        pend_v    <= 1'b0;
        sof_due   <= 1'b0;
        out_valid <= !port_bad;
        out_data  <= pend_v ? pend_d : '0;
        out_sof   <= sof_due && !port_bad;
        out_eof   <= !port_bad;
        out_drop  <= fin_drop && !port_bad;
        out_bytes <= fin_bytes;
        frame_len <= fin_len;
      end
    end
  end
endmodule

// File: rtl/extr_decoder_chk.sv
module extr_decoder_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eof,
  input logic             out_drop,
  input logic [2:0]       out_bytes,
  input logic [LEN_W-1:0] frame_len,
  input logic             flush_req
);
  // R3
  full_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eof) |-> (out_bytes == 3'd4));
  // R4
  eof_beat_chk: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> out_valid);
  // R4
  kept_bytes_chk: assert property (@(posedge clk) disable iff (rst)
    (out_eof && !out_drop) |-> (out_bytes != 3'd0 && out_bytes <= 3'd4));
  // R5
  drop_len_chk: assert property (@(posedge clk) disable iff (rst)
    (out_eof && out_drop) |-> (frame_len == '0));
  // R8
  one_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);
  // R11
  flush_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> !flush_req);
  // R3
  sof_beat_chk: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
endmodule

bind extr_decoder extr_decoder_chk #(.LEN_W(LEN_W)) chk_i (.*);

// File: tb/extr_decoder_tb_top.sv
`timescale 1ns/1ps
module extr_decoder_tb_top;
  localparam int HDRW = 9;

  logic clk = 1'b0, rst = 1'b1, swap_en = 1'b0, in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic in_ready, out_valid, out_sof, out_eof, out_drop, flush_req;
  logic [31:0] out_data;
  logic [2:0] out_bytes;
  logic [15:0] frame_len;
  logic [6:0] src_port;
  logic [HDRW*32-1:0] hdr_bits;

  always #4 clk = ~clk;

  extr_decoder dut_i (
    .clk(clk), .rst(rst), .swap_en(swap_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .out_bytes(out_bytes), .out_drop(out_drop), .frame_len(frame_len),
    .src_port(src_port), .flush_req(flush_req), .hdr_bits(hdr_bits)
  );

  // stimulus/expected: swap, end kind, data words, port, last bytes, drop, length
  localparam logic [38:0] VEC [8] = '{
    {1'b0, 3'd0, 8'd3,  7'd5,  3'd4, 1'b0, 16'd8},
    {1'b0, 3'd1, 8'd5,  7'd64, 3'd3, 1'b0, 16'd15},
    {1'b1, 3'd2, 8'd16, 7'd0,  3'd2, 1'b0, 16'd58},
    {1'b1, 3'd3, 8'd2,  7'd33, 3'd1, 1'b0, 16'd1},
    {1'b0, 3'd3, 8'd1,  7'd7,  3'd1, 1'b0, 16'd0},
    {1'b0, 3'd4, 8'd4,  7'd9,  3'd4, 1'b1, 16'd0},
    {1'b1, 3'd5, 8'd3,  7'd10, 3'd4, 1'b1, 16'd0},
    {1'b0, 3'd5, 8'd0,  7'd1,  3'd0, 1'b1, 16'd0}
  };

  int n_chk = 0, n_fail = 0;
  int mon_n = 0, fl_n = 0, nr_n = 0;
  logic [31:0] m_d [256];
  logic m_sof [256], m_eof [256], m_drop [256];
  logic [2:0] m_b [256];
  logic [15:0] m_len [256];
  logic [31:0] exp_d [64];
  int exp_n = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        m_d[mon_n % 256]    = out_data;
        m_sof[mon_n % 256]  = out_sof;
        m_eof[mon_n % 256]  = out_eof;
        m_drop[mon_n % 256] = out_drop;
        m_b[mon_n % 256]    = out_bytes;
        m_len[mon_n % 256]  = frame_len;
        mon_n++;
      end
      if (flush_req) fl_n++;
      if (!in_ready) nr_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] code(input int k, input logic sw);
    logic [31:0] c;
    c = 32'h8000_0000 | 32'(k);
    return sw ? rev(c) : c;
  endfunction

  function automatic logic [31:0] mk(input int i);
    return 32'h0A0B_0C00 ^ (32'(i) * 32'h0101_0101);
  endfunction

  task automatic put(input logic [31:0] w);
    logic rdy;
    in_word  = w;
    in_valid = 1'b1;
    forever begin
      rdy = in_ready;
      @(negedge clk);
      if (rdy) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic put_d(input logic [31:0] w);
    put(w);
    exp_d[exp_n] = w;
    exp_n++;
  endtask

  task automatic send_hdr(input logic [6:0] port);
    logic [31:0] w;
    int base;
    base = mon_n;
    for (int i = 0; i < HDRW; i++) begin
      if (i == 0) w = 32'h8000_0005;
      else if (i == 7)
        w = (32'hA5A5_A5A5 & 32'hFF3F_E0FF) | (32'(port[6:2]) << 8) | (32'(port[1:0]) << 22);
      else w = 32'hC0DE_0000 + 32'(i);
      put(w);
    end
    chk("R1 no beat from header", 32'(mon_n - base), 0);
    chk("R1 header word 0 stored", hdr_bits[31:0], 32'h8000_0005);
    chk("R2 src_port", 32'(src_port), 32'(port));
  endtask

  task automatic end_check(input string req, input int base, input logic [2:0] xb,
                           input logic xdrop, input logic [15:0] xlen);
    int nb, ix;
    repeat (3) @(negedge clk);
    nb = mon_n - base;
    chk({req, " beat count"}, 32'(nb), 32'(exp_n));
    for (int i = 0; i < nb && i < exp_n; i++) begin
      ix = (base + i) % 256;
      chk("R3 data", m_d[ix], exp_d[i]);
      chk("R3 sof", 32'(m_sof[ix]), 32'(i == 0));
      chk("R4 eof", 32'(m_eof[ix]), 32'(i == exp_n - 1));
      if (i == exp_n - 1) begin
        chk({req, " last bytes"}, 32'(m_b[ix]), 32'(xb));
        chk({req, " drop"}, 32'(m_drop[ix]), 32'(xdrop));
        chk({req, " R5 length"}, 32'(m_len[ix]), 32'(xlen));
      end else begin
        chk("R3 full word", 32'(m_b[ix]), 32'd4);
      end
    end
  endtask

  task automatic run_row(input logic [38:0] v);
    logic sw; int ek, nd, base, nrb; logic [6:0] pt;
    sw = v[38]; ek = int'(v[37:35]); nd = int'(v[34:27]); pt = v[26:20];
    swap_en = sw; exp_n = 0; base = mon_n; nrb = nr_n;
    send_hdr(pt);
    for (int i = 0; i < nd; i++) put_d(mk(i));
    if (ek < 4) put(code(ek, sw));
    else if (ek == 4) begin put(code(4, sw)); put_d(mk(nd)); end
    else begin
      put(code(5, sw));
      if (nd == 0) begin exp_d[0] = '0; exp_n = 1; end
    end
    end_check(ek < 4 ? "R4/R10" : (ek == 4 ? "R8" : "R9"), base, v[19:17], v[16], v[15:0]);
    if (ek == 4) chk("R8 single stall", 32'(nr_n - nrb), 1);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base, flb;
    repeat (2) @(negedge clk);
    chk("R12 out_valid in reset", 32'(out_valid), 0);
    chk("R12 flush_req in reset", 32'(flush_req), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 in_ready after reset", 32'(in_ready), 1);
    chk("R12 out_valid after reset", 32'(out_valid), 0);

    for (int r = 0; r < 8; r++) run_row(VEC[r]);

    // R6/R7: escaped literals and idle codes
    swap_en = 1'b0; exp_n = 0; base = mon_n;
    send_hdr(7'd3);
    put_d(mk(0)); put(code(6, 1'b0)); put_d(32'h8000_0000);
    put(code(6, 1'b0)); put_d(32'h8000_0007); put(code(7, 1'b0));
    put_d(mk(1)); put(code(0, 1'b0));
    end_check("R6", base, 3'd4, 1'b0, 16'd12);

    // R7: idle codes contribute nothing
    exp_n = 0; base = mon_n;
    send_hdr(7'd4);
    put(code(7, 1'b0)); put_d(mk(0)); put(code(7, 1'b0)); put(code(7, 1'b0));
    put_d(mk(1)); put(code(1, 1'b0));
    end_check("R7", base, 3'd3, 1'b0, 16'd3);

    // R10: unreversed code pattern is data while swap is on
    swap_en = 1'b1; exp_n = 0; base = mon_n;
    send_hdr(7'd12);
    put_d(mk(0)); put_d(32'h8000_0001); put(code(0, 1'b1));
    end_check("R10", base, 3'd4, 1'b0, 16'd4);

    // R11: unknown port is flushed and silenced
    swap_en = 1'b0; exp_n = 0; base = mon_n; flb = fl_n;
    send_hdr(7'd100);
    put(mk(0)); put(mk(1)); put(code(0, 1'b0));
    repeat (3) @(negedge clk);
    chk("R11 flush pulse count", 32'(fl_n - flb), 1);
    chk("R11 no beats", 32'(mon_n - base), 0);

    // R11: next frame on a valid port is unaffected
    run_row(VEC[0]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule